// File: doc/BRIEF.md
# Consecutive-Small-Sample Decision Window

This block watches a stream of signed 16-bit fixed-point samples and raises a per-sample "small" flag. The flag tells the multipliers further down a filter's delay line that they may skip their product. Each valid sample first goes through an amplitude detector. The detector marks the sample when its magnitude lies below an input threshold. A run counter then raises the flag only once a configurable number of consecutive valid samples have been marked. Short dips in amplitude therefore do not switch the multipliers on and off from one sample to the next.

A parameter selects how the detector is built. In the fixed variant the threshold is a power of two, 2^THR_LOG2 LSBs; the default of 256 LSBs equals 2^-7 in Q1.15. This variant is pure gate logic over the upper sample bits. In the comparator variant the threshold comes in on a port and is compared against the absolute value of the sample. The sample is registered alongside the flag, so the two leave the block aligned with one clock of latency. Cycles without sample-valid leave all state untouched.

Top module: `small_run_window`

## Requirements
- R1: While rst_ni is low, flag_o is 0 and sample_o is 0. The run count restarts from zero after reset.
- R2: In fixed mode with the default THR_LOG2 = 8, a sample is small exactly when |x| < 256. So +255, -255, 0 and -1 are small, and +256, -256, +32767 and -32768 are not.
- R3: A valid sample that is not small clears the run count. flag_o is then 0 in the cycle after that sample.
- R4: flag_o becomes 1 in the cycle after the RUN_LEN-th consecutive small valid sample, with RUN_LEN = 4 by default. It stays 1 after each further small valid sample, because the count saturates at RUN_LEN.
- R5: After each clock edge with valid_i high, sample_o equals the sample_i presented at that edge. flag_o belongs to that same sample.
- R6: A clock edge with valid_i low changes neither flag_o, nor sample_o, nor the run count. A run of small samples split by invalid cycles still counts as consecutive.
- R7: In comparator mode, a sample is small exactly when its absolute value, computed without overflow (|-32768| = 32768), is below the unsigned thr_i. With thr_i = 0 no sample is small.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| sample_i | input | DATA_W | Signed sample, Q1.15 by default |
| thr_i | input | DATA_W | Unsigned magnitude threshold, used in comparator mode only |
| flag_o | output | 1 | Registered small-run flag |
| sample_o | output | DATA_W | Sample delayed by one valid cycle, aligned with flag_o |

## Verification
Suppose the run count were off by one, failed to saturate, or were not cleared by a large sample. flag_o would then go high one sample early or late, drop during a long quiet run, or stay high after a large sample. Each of these shows in the cycle right after the sample concerned. A wrong detector boundary shows up when a sample at exactly ±threshold raises the flag after enough repeats. Mishandled valid gating shows up as a change in sample_o or flag_o across an idle cycle.

// File: rtl/srw_pkg.sv
package srw_pkg;
  typedef enum logic {
    DET_FIXED = 1'b0,
    DET_CMP   = 1'b1
  } det_mode_e;
endpackage

// File: rtl/srw_amp_detect.sv
module srw_amp_detect
  import srw_pkg::*;
#(
  parameter int        DATA_W   = 16,
  parameter int        THR_LOG2 = 8,
  parameter det_mode_e MODE     = DET_FIXED
) (
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0] thr_i,
  output logic              small_o
);
  localparam int HI_W = DATA_W - THR_LOG2;

  generate
    if (MODE == DET_FIXED) begin : g_fixed
      logic [HI_W-1:0] hi;
      logic            lo_nz;
      logic            unused_thr;
      assign unused_thr = ^thr_i;
      assign hi         = sample_i[DATA_W-1:THR_LOG2];
      assign lo_nz      = |sample_i[THR_LOG2-1:0];
      // positive: upper bits all zero; negative: all ones and value above -2^K
      assign small_o    = (~|hi) | ((&hi) & lo_nz);
    end else begin : g_cmp
      logic [DATA_W:0] ext;
      logic [DATA_W:0] mag;
      assign ext     = {sample_i[DATA_W-1], sample_i};
      assign mag     = ext[DATA_W] ? (~ext + 1'b1) : ext;
      assign small_o = mag < {1'b0, thr_i};
    end
  endgenerate
endmodule

// File: rtl/srw_run_count.sv
module srw_run_count #(
  parameter int RUN_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic small_i,
  output logic hit_o
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit_q;

  always_comb begin
    cnt_d = cnt_q;
    if (valid_i) begin
      if (!small_i)              cnt_d = '0;
      else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else if (valid_i) begin
      cnt_q <= cnt_d;
      hit_q <= (cnt_d == CNT_MAX);
    end
  end

  assign hit_o = hit_q;
endmodule

// File: rtl/small_run_window.sv
module small_run_window
  import srw_pkg::*;
#(
  parameter int        DATA_W   = 16,
  parameter int        THR_LOG2 = 8,
  parameter int        RUN_LEN  = 4,
  parameter det_mode_e DET_MODE = DET_FIXED
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0] thr_i,
  output logic              flag_o,
  output logic [DATA_W-1:0] sample_o
);
  logic              small_w;
  logic [DATA_W-1:0] sample_q;

  srw_amp_detect #(
    .DATA_W  (DATA_W),
    .THR_LOG2(THR_LOG2),
    .MODE    (DET_MODE)
  ) u_det (
    .sample_i(sample_i),
    .thr_i   (thr_i),
    .small_o (small_w)
  );

  srw_run_count #(
    .RUN_LEN(RUN_LEN)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .small_i(small_w),
    .hit_o  (flag_o)
  );

  // delay stage matching the counter's register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sample_q <= '0;
    else if (valid_i) sample_q <= sample_i;
  end

  assign sample_o = sample_q;
endmodule

// File: rtl/srw_checker.sv
module srw_checker #(
  parameter int DATA_W  = 16,
  parameter int RUN_LEN = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] sample_i,
  input logic              small_i,
  input logic              flag_o,
  input logic [DATA_W-1:0] sample_o
);
  localparam int CW = $clog2(RUN_LEN + 1) + 1;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (valid_i) begin
      if (!small_i)                   run_q <= '0;
      else if (run_q < CW'(RUN_LEN))  run_q <= run_q + 1'b1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!flag_o && sample_o == '0));

  assert_large_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !small_i) |=> !flag_o);

  assert_run_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o == (run_q == CW'(RUN_LEN)));

  assert_delay_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> sample_o == $past(sample_i));

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(flag_o) && $stable(sample_o)));
endmodule

bind small_run_window srw_checker #(
  .DATA_W (DATA_W),
  .RUN_LEN(RUN_LEN)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .sample_i(sample_i),
  .small_i (small_w),
  .flag_o  (flag_o),
  .sample_o(sample_o)
);

// File: tb/tb_small_run_window.sv
`timescale 1ns/1ps
module tb_small_run_window;
  import srw_pkg::*;

  localparam int NV = 17;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] sample_i = '0;
  logic [15:0] thr_i = '0;
  logic        flag_o, pflag_o;
  logic [15:0] sample_o, psample_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  small_run_window dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sample_i(sample_i),
    .thr_i(thr_i), .flag_o(flag_o), .sample_o(sample_o));

  small_run_window #(.DET_MODE(DET_CMP)) dut_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sample_i(sample_i),
    .thr_i(thr_i), .flag_o(pflag_o), .sample_o(psample_o));

  // valid, sample, expected flag (fixed mode, threshold 256, run 4)
  localparam logic        V_V [NV] = '{1,1,1,1,1,0,1,1,1,1,1,1,0,1,1,1,1};
  localparam logic [15:0] V_X [NV] = '{16'd10, -16'sd5, 16'd255, -16'sd255, 16'd0,
                                       16'd9999, 16'd256, 16'd1, 16'd2, -16'sd256,
                                       16'd3, 16'd3, 16'h8000, 16'd3, 16'hFFFF,
                                       16'h8000, 16'h7FFF};
  localparam logic        V_F [NV] = '{0,0,0,1,1,1,0,0,0,0,0,0,0,0,1,0,0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [15:0] x);
    @(negedge clk_i);
    valid_i  = v;
    sample_i = x;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] exp_s;
    #7;
    chk("R1 flag in reset", flag_o, 0);
    chk("R1 sample in reset", sample_o, 0);
    @(negedge clk_i) rst_ni = 1'b1;

    // table walk: R2 R3 R4 R5 R6
    exp_s = '0;
    for (int i = 0; i < NV; i++) begin
      step(V_V[i], V_X[i]);
      if (V_V[i]) exp_s = V_X[i];
      chk($sformatf("R4/R3/R2 flag vec %0d", i), flag_o, V_F[i]);
      chk($sformatf("R5/R6 sample vec %0d", i), sample_o, exp_s);
    end

    // R2 boundary: +256 repeated never flags, -255 repeated does
    for (int i = 0; i < 5; i++) step(1, 16'd256);
    chk("R2 +256 not small", flag_o, 0);
    for (int i = 0; i < 4; i++) step(1, -16'sd255);
    chk("R2 -255 small", flag_o, 1);
    for (int i = 0; i < 6; i++) step(1, 16'd255);
    chk("R4 saturates in long run", flag_o, 1);
    step(1, 16'h8000);
    chk("R3 -32768 clears", flag_o, 0);

    // R7 comparator mode
    thr_i = 16'd100;
    for (int i = 0; i < 4; i++) step(1, 16'd99);
    chk("R7 99 below 100", pflag_o, 1);
    step(1, 16'd100);
    chk("R7 100 not below 100", pflag_o, 0);
    for (int i = 0; i < 4; i++) step(1, -16'sd99);
    chk("R7 -99 below 100", pflag_o, 1);
    step(1, -16'sd100);
    chk("R7 -100 not below 100", pflag_o, 0);
    thr_i = 16'hFFFF;
    for (int i = 0; i < 4; i++) step(1, 16'h8000);
    chk("R7 |-32768| below 65535", pflag_o, 1);
    chk("R7 sample path", psample_o, 16'h8000);
    thr_i = 16'd0;
    for (int i = 0; i < 5; i++) step(1, 16'd0);
    chk("R7 zero threshold", pflag_o, 0);

    // R1 mid-run reset, then count restarts
    for (int i = 0; i < 4; i++) step(1, 16'd1);
    chk("R4 before reset", flag_o, 1);
    @(negedge clk_i) begin valid_i = 0; rst_ni = 0; end
    #1;
    chk("R1 async clear flag", flag_o, 0);
    chk("R1 async clear sample", sample_o, 0);
    @(negedge clk_i) rst_ni = 1;
    for (int i = 0; i < 3; i++) step(1, 16'd1);
    chk("R1 count restarted", flag_o, 0);
    step(1, 16'd1);
    chk("R4 after restart", flag_o, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule